// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the target side of a four-wire serial memory link: chip select, serial clock, data in and data out. It runs on a fast system clock and oversamples the serial lines. It waits for a start bit, then gathers a two-bit opcode, an address and, for the two data-carrying instructions, a data word. The opcode, the two top address bits and two mode pins together select one of ten instructions. Those pins are a protect-mode select and a program enable.

Reads return one dummy zero and then data words, most significant bit first. A word read keeps streaming the following words, with the address wrapping around, for as long as chip select stays high. Write-type instructions take effect only when chip select falls after a complete, well-formed frame.

The storage behind the front end is a register array. It is guarded by a write-enable latch and by a protection boundary: every address at or above the boundary refuses writes. That boundary can be frozen for good.

Top module: `sereeprom_frontend`

## Requirements
- R1: While chip select is low, dout_oe is 0 and sk/di activity has no effect; a rising chip select restarts frame collection from the start-bit hunt.
- R2: di is sampled on sk rising edges; any number of 0 bits ahead of the first 1 are skipped, and that 1 is the start bit.
- R3: With pre low, opcode 10 followed by the address is a word read. At the sk rise that takes the last address bit, dout_oe goes to 1 with dout 0 (the dummy bit). The next 16 rises put out the word at that address, bit 15 first.
- R4: If chip select stays high during a word read, the next word (address plus one, wrapping from the top address to 0) follows bit 15 first right after bit 0, with no gap.
- R5: With pre low and pe high, opcode 01, the address and 16 data bits (MSB first) write the word when chip select falls, provided writes are enabled and the address is not protected.
- R6: Writes start disabled after reset. With pre low, opcode 00 and top address bits 11 (pe high) enables them, and opcode 00 with top bits 00 disables them. A write while disabled leaves memory unchanged.
- R7: With pre low and pe high, opcode 00 with top address bits 01 and a 16-bit data word writes every location at chip-select fall. This happens only when writes are enabled and no protection boundary is armed.
- R8: Frames that are incomplete at chip-select fall, frames that need pe high but have pe low, and undefined codes (such as pre low with opcode 11) change nothing and never drive dout.
- R9: With pre high, opcode 10 returns the 16-bit protect status: bit 15 is locked, bit 14 is armed, the low address bits hold the boundary, and the other bits are 0. After reset the status is unlocked, unarmed, with the boundary all ones. dout_oe drops at the rise after the last bit.
- R10: With pre high and pe high, opcode 00 with top bits 11 sets a one-shot protect-change permit, which requires writes to be enabled. Any later committed instruction consumes the permit. Opcode 01 with an address, when permitted, sets the boundary to that address and arms it.
- R11: With pre high and pe high, opcode 11 with an all-ones address, when permitted, disarms protection and resets the boundary to all ones.
- R12: With pre high and pe high, opcode 00 with an all-zero address, when permitted, locks the protect state. After that, no further instruction changes the boundary or the armed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| pre | input | 1 | Selects protect-state instructions when high |
| pe | input | 1 | Program enable for write-type instructions |
| dout | output | 1 | Serial read data |
| dout_oe | output | 1 | Output enable for dout (0 means high impedance) |

## Verification
The bench builds the block with a 4-bit address and 16-bit words. With only sixteen locations, every address can be written with its own pattern and read back one by one. A single sequential read can then cross the wrap from the last word to word 0. The protection boundary, the write-all refusal while the boundary is armed, and the permanent lock can all be checked against a full sixteen-entry model computed in the bench.

// File: rtl/sereeprom_frontend.sv
module sereeprom_frontend #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic pre,
  input  logic pe,
  output logic dout,
  output logic dout_oe
);
  localparam int HW    = 2 + AW;
  localparam int WORDS = 1 << AW;
  localparam int MX    = (HW > DW) ? HW : DW;
  localparam int CW    = $clog2(MX);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE, S_DROP} st_t;
  typedef enum logic [3:0] {C_NONE, C_READ, C_WRITE, C_WRALL, C_WEN, C_WDS,
                            C_PRRD, C_PREN, C_PRCLR, C_PRWR, C_PRDS} cmd_t;

  logic cs_s, cs_q, sk_s, sk_q, di_s;
  st_t  st;
  cmd_t cmd, dec;
  logic [HW-2:0] hdr;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr, prot;
  logic [DW-1:0] wdat, osh;
  logic [DW-1:0] mem [WORDS];
  logic wen, pren, armed, locked;

  wire rise    = cs_s & sk_s & ~sk_q;
  wire cs_fall = cs_q & ~cs_s;
  wire [HW-1:0] full = {hdr, di_s};
  wire [1:0]    op   = full[HW-1:HW-2];
  wire [AW-1:0] fa   = full[AW-1:0];
  wire [1:0]    top  = fa[AW-1:AW-2];
  wire [AW-1:0] nxt  = addr + 1'b1;
  wire [DW-1:0] prword = {locked, armed, {(DW-AW-2){1'b0}}, prot};
  wire blocked = armed && (addr >= prot);
  wire permit  = pren && wen && !locked;

  always_comb begin
    dec = C_NONE;
    if (!pre) begin
      case (op)
        2'b10: dec = C_READ;
        2'b01: if (pe) dec = C_WRITE;
        2'b00: begin
          if (top == 2'b11 && pe) dec = C_WEN;
          else if (top == 2'b01 && pe) dec = C_WRALL;
          else if (top == 2'b00) dec = C_WDS;
        end
        default: dec = C_NONE;
      endcase
    end else begin
      case (op)
        2'b10: dec = C_PRRD;
        2'b00: begin
          if (pe && top == 2'b11) dec = C_PREN;
          else if (pe && fa == '0) dec = C_PRDS;
        end
        2'b11: if (pe && (&fa)) dec = C_PRCLR;
        2'b01: if (pe) dec = C_PRWR;
        default: dec = C_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 1'b0; cs_q <= 1'b0; sk_s <= 1'b0; sk_q <= 1'b0; di_s <= 1'b0;
      st <= S_IDLE; cmd <= C_NONE; hdr <= '0; cnt <= '0; addr <= '0;
      wdat <= '0; osh <= '0; dout <= 1'b0; dout_oe <= 1'b0;
    end else begin
      cs_s <= cs; cs_q <= cs_s; sk_s <= sk; sk_q <= sk_s; di_s <= di;
      if (!cs_s || !cs_q) begin
        st <= S_IDLE;
        dout <= 1'b0;
        dout_oe <= 1'b0;
      end else if (rise) begin
        case (st)
          S_IDLE: if (di_s) begin
            st  <= S_HDR;
            cnt <= '0;
          end
          S_HDR: begin
            hdr <= {hdr[HW-3:0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW-1)) begin
              cnt  <= '0;
              cmd  <= dec;
              addr <= fa;
              case (dec)
                C_READ, C_PRRD: begin
                  osh     <= (dec == C_READ) ? mem[fa] : prword;
                  dout    <= 1'b0;
                  dout_oe <= 1'b1;
                  st      <= S_READ;
                end
                C_WRITE, C_WRALL: st <= S_DATA;
                C_NONE:           st <= S_DROP;
                default:          st <= S_DONE;
              endcase
            end
          end
          S_DATA: begin
            wdat <= {wdat[DW-2:0], di_s};
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              cnt <= '0;
              st  <= S_DONE;
            end
          end
          S_READ: begin
            dout <= osh[DW-1];
            osh  <= {osh[DW-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              cnt <= '0;
              if (cmd == C_READ) begin
                addr <= nxt;
                osh  <= mem[nxt];
              end else begin
                st <= S_DROP;
              end
            end
          end
          S_DROP: dout_oe <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      wen <= 1'b0; pren <= 1'b0; armed <= 1'b0; locked <= 1'b0; prot <= '1;
    end else if (cs_fall && st == S_DONE) begin
      pren <= (cmd == C_PREN) && wen;
      case (cmd)
        C_WEN:   wen <= 1'b1;
        C_WDS:   wen <= 1'b0;
        C_WRITE: if (wen && !blocked) mem[addr] <= wdat;
        C_WRALL: if (wen && !armed)
                   for (int i = 0; i < WORDS; i++) mem[i] <= wdat;
        C_PRCLR: if (permit) begin
                   armed <= 1'b0;
                   prot  <= '1;
                 end
        C_PRWR:  if (permit) begin
                   armed <= 1'b1;
                   prot  <= addr;
                 end
        C_PRDS:  if (permit) locked <= 1'b1;
        default: ;
      endcase
    end
  end

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !dout_oe);
  a_r2_zero_keeps_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rise && !di_s && cs) |=> st == S_IDLE);
  a_r3_dummy_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);
  a_r8_drive_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (st == S_READ || st == S_DROP));
  a_r6_enable_moves_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(cs_fall));
  a_r12_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(prot) && $stable(armed)));
endmodule

// File: tb/sereeprom_frontend_bench.sv
module sereeprom_frontend_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pre = 1'b0, pe = 1'b0;
  logic dout, dout_oe;
  logic lo, le;
  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] m [N];

  always #2 clk = ~clk;

  sereeprom_frontend #(.AW(AW), .DW(DW)) u_sereeprom_frontend (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pre(pre), .pe(pe),
    .dout(dout), .dout_oe(dout_oe));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return 16'hA5C3 ^ 16'(a * 16'h1111);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic skbit(logic b);
    di = b; sk = 1'b0; tick(4);
    sk = 1'b1; tick(4);
    lo = dout; le = dout_oe;
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) skbit(v[i]);
  endtask

  task automatic open(logic p, logic e);
    pre = p; pe = e; sk = 1'b0; cs = 1'b1; tick(4);
  endtask

  task automatic close;
    sk = 1'b0; tick(2); cs = 1'b0; tick(6);
  endtask

  task automatic cmd(logic p, logic e, logic [1:0] op, logic [AW-1:0] a);
    open(p, e); skbit(1'b1); send(op, 2); send(a, AW); close();
  endtask

  task automatic wr(logic e, int a, logic [DW-1:0] d);
    open(1'b0, e); skbit(1'b1); send(2'b01, 2); send(a, AW); send(d, DW); close();
  endtask

  task automatic wrall(logic [DW-1:0] d);
    open(1'b0, 1'b1); skbit(1'b1); send(2'b00, 2); send(4'h4, AW); send(d, DW); close();
  endtask

  task automatic get_word(output logic [DW-1:0] w);
    for (int i = DW - 1; i >= 0; i--) begin
      skbit(1'b0);
      w[i] = lo;
    end
  endtask

  task automatic rd(string tag, int a, int n);
    logic [DW-1:0] w;
    open(1'b0, 1'b0); skbit(1'b1); send(2'b10, 2); send(a, AW);
    chk({tag, " R3 dummy"}, {le, lo}, 2'b10);
    for (int k = 0; k < n; k++) begin
      get_word(w);
      chk(tag, w, m[(a + k) % N]);
    end
    close();
  endtask

  task automatic prrd(string tag, logic [DW-1:0] exp);
    logic [DW-1:0] w;
    open(1'b1, 1'b0); skbit(1'b1); send(2'b10, 2); send(0, AW);
    get_word(w);
    chk({tag, " R9 status"}, w, exp);
    skbit(1'b0);
    chk({tag, " R9 release"}, le, 1'b0);
    close();
  endtask

  initial begin
    for (int i = 0; i < N; i++) m[i] = '0;
    tick(3); rst_n = 1'b1; tick(3);
    chk("R1 reset oe", dout_oe, 1'b0);
    rd("R3 reset read", 3, 1);

    wr(1'b1, 3, 16'hBEEF);
    rd("R6 write while disabled", 3, 1);
    cmd(1'b0, 1'b1, 2'b00, 4'hC);
    for (int a = 0; a < N; a++) begin
      wr(1'b1, a, pat(a));
      m[a] = pat(a);
    end
    for (int a = 0; a < N; a++) rd("R5 write readback", a, 1);
    rd("R4 sequential wrap", 14, 20);

    open(1'b0, 1'b0);
    send(0, 5); skbit(1'b1); send(2'b10, 2); send(5, AW);
    chk("R2 dummy after zeros", {le, lo}, 2'b10);
    begin
      logic [DW-1:0] w;
      get_word(w);
      chk("R2 leading zeros read", w, m[5]);
    end
    close();

    wr(1'b0, 6, 16'h0BAD);
    rd("R8 pe low write", 6, 1);
    open(1'b0, 1'b1); skbit(1'b1); send(2'b11, 2); send(6, AW);
    send(16'h1234, DW);
    chk("R8 malformed no drive", le, 1'b0);
    close();
    rd("R8 malformed ignored", 6, 1);
    open(1'b0, 1'b1); skbit(1'b1); send(2'b01, 2); send(2, AW); send(5'h1F, 5); close();
    rd("R8 incomplete discarded", 2, 1);

    pre = 1'b0; pe = 1'b1; cs = 1'b0;
    begin
      logic bad = 1'b0;
      for (int i = 0; i < 12; i++) begin
        skbit(i < 3);
        if (le !== 1'b0) bad = 1'b1;
      end
      chk("R1 idle sk ignored", bad, 1'b0);
    end
    open(1'b0, 1'b1); skbit(1'b1); send(2'b01, 2); send(2, AW); send(16'h00FF, 8);
    cs = 1'b0; tick(6);
    wr(1'b1, 2, 16'h2222); m[2] = 16'h2222;
    rd("R1 restart after cs rise", 2, 1);

    wrall(16'h3C3C);
    for (int i = 0; i < N; i++) m[i] = 16'h3C3C;
    rd("R7 write all", 0, N);

    prrd("R9 reset", 16'h000F);
    cmd(1'b1, 1'b1, 2'b00, 4'hC);
    cmd(1'b1, 1'b1, 2'b01, 4'h8);
    prrd("R10 armed", 16'h4008);
    wr(1'b1, 9, 16'h1111);
    wr(1'b1, 7, 16'h7777); m[7] = 16'h7777;
    rd("R10 above boundary", 9, 1);
    rd("R10 below boundary", 7, 1);
    wrall(16'h5555);
    rd("R7 write all blocked", 0, 1);
    cmd(1'b1, 1'b1, 2'b01, 4'h2);
    prrd("R10 permit consumed", 16'h4008);

    cmd(1'b1, 1'b1, 2'b00, 4'hC);
    cmd(1'b1, 1'b1, 2'b11, 4'hF);
    prrd("R11 cleared", 16'h000F);
    wr(1'b1, 9, 16'h9999); m[9] = 16'h9999;
    rd("R11 write after clear", 9, 1);

    cmd(1'b1, 1'b1, 2'b00, 4'hC);
    cmd(1'b1, 1'b1, 2'b01, 4'hC);
    cmd(1'b1, 1'b1, 2'b00, 4'hC);
    cmd(1'b1, 1'b1, 2'b00, 4'h0);
    prrd("R12 locked", 16'hC00C);
    cmd(1'b1, 1'b1, 2'b00, 4'hC);
    cmd(1'b1, 1'b1, 2'b11, 4'hF);
    prrd("R12 clear refused", 16'hC00C);
    wr(1'b1, 13, 16'hDDDD);
    wr(1'b1, 11, 16'hBBBB); m[11] = 16'hBBBB;
    rd("R12 protected word", 13, 1);
    rd("R12 open word", 11, 1);

    cmd(1'b0, 1'b0, 2'b00, 4'h0);
    wr(1'b1, 0, 16'h0F0F);
    rd("R6 disabled again", 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule